// File: doc/BRIEF.md
# DC-Level IIR Averager with Periodic Clear

This block tracks the DC level of a stream of signed samples that arrive at most once per clock. A single-pole recursive low-pass filter moves its state toward each new sample by a fraction 2^-D of the gap. D is a 5-bit shift setting, so each step up in D roughly halves the filter bandwidth. The state carries 20 fraction bits below the input LSB, and the output is that state rounded back to the input width.

An optional clear mode bounds how far back the estimate looks. A sample counter runs, and the sample that completes each window of 2^R accepted samples is loaded straight into the state, which discards the history. R is a 5-bit setting. When clear mode is off, the filter runs without end. The mode is only meaningful with D below R, and a registered error flag reports any other setting. Configuration arrives on plain level ports.

Top module: `dc_meas_averager`

## Requirements
- R1: After synchronous reset, out_valid is 0, out_data is 0 and cfg_error is 0.
- R2: Each accepted sample x (in_valid=1 while en=1) updates the 36-bit state y, which carries 20 fraction bits, as y <= y + ((x*2^20 - y) >>> D). out_data is (y + 2^19) >>> 20, an arithmetic shift that rounds halves upward. For D=4 a step settles to within 1 LSB of the target after 128 samples.
- R3: A shift setting above 20 behaves exactly like 20.
- R4: With shift setting 0 the filter is a pass-through: out_data equals the sample accepted one cycle earlier.
- R5: out_valid is high for exactly one cycle, the cycle after a sample is accepted, and at no other time.
- R6: While en=0 the state is held at zero, out_data reads 0, samples are ignored and out_valid stays 0.
- R7: With clr_en=1, a counter of accepted samples runs. The 2^R-th accepted sample since the counter started is loaded directly as the state, and the count begins again. The counter restarts from zero in any cycle in which en, clr_en or the R setting differ from their values in the previous cycle.
- R8: With clr_en=0 the state is never cleared. Every accepted sample applies the R2 update.
- R9: cfg_error is high in the cycle after one in which en=1, clr_en=1 and D >= R hold (D compared as the raw 5-bit value), and it is low otherwise.
- R10: In a cycle without an accepted sample the state and out_data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample period |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Filter enable |
| shift_d | input | 5 | Coefficient shift D |
| clr_en | input | 1 | Periodic-clear mode enable |
| clr_r | input | 5 | Clear window exponent R |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed sample |
| out_valid | output | 1 | Pulses after each accepted sample |
| out_data | output | 16 | Rounded signed DC estimate |
| cfg_error | output | 1 | D >= R while clear mode is enabled |

## Verification
The bench aims at the clear boundary. A window that is off by one shows up as an output that fails to equal the sample at exactly the 2^R-th position, and a counter that is not restarted when R changes shifts every later clear. It drives shift settings of 0, 20 and above 20: a design that does not clamp the shift, or that drops fraction bits, drifts away from the rounded reference within a few hundred samples. Gaps in the sample strobe, disabling, and a step response that must settle after 8*2^D samples catch state that moves without a sample, a valid pulse that is stretched, and a wrong rounding or shift direction.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam int DATA_W    = 16;
    localparam int FRAC_W    = 20;
    localparam int CFG_W     = 5;
    localparam int MAX_SHIFT = 20;
    localparam int CNT_W     = 32;

    typedef struct packed {
        logic             en;
        logic             clr_en;
        logic [CFG_W-1:0] win_exp;
    } win_cfg_t;

    function automatic logic [CFG_W-1:0] clamp_shift(input logic [CFG_W-1:0] d);
        return (int'(d) > MAX_SHIFT) ? CFG_W'(MAX_SHIFT) : d;
    endfunction
endpackage

// File: rtl/dcm_window_timer.sv
module dcm_window_timer
    import dcm_pkg::*;
#(
    parameter int CNT_BITS = CNT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  win_cfg_t cfg,
    input  logic     in_valid,
    output logic     wrap
);
    win_cfg_t            cfg_q;
    logic [CNT_BITS-1:0] cnt_q;
    logic [CNT_BITS-1:0] cnt_eff;
    logic [CNT_BITS-1:0] mask;
    logic                changed;

    assign changed = (cfg != cfg_q);
    assign cnt_eff = changed ? '0 : cnt_q;
    assign mask    = (CNT_BITS'(1) << cfg.win_exp) - CNT_BITS'(1);
    assign wrap    = cfg.en && cfg.clr_en && in_valid && (cnt_eff == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else begin
            cfg_q <= cfg;
            if (!cfg.en || !cfg.clr_en) cnt_q <= '0;
            else if (in_valid)          cnt_q <= wrap ? '0 : cnt_eff + CNT_BITS'(1);
            else                        cnt_q <= cnt_eff;
        end
    end

    // R7: in a steady configuration the count never passes the window end
    assert_cnt_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.clr_en && !changed) |-> (cnt_q <= mask));
endmodule

// File: rtl/dcm_iir_core.sv
module dcm_iir_core
    import dcm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CFG_W-1:0]     shift_d,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic                 wrap,
    output logic signed [DW+FW-1:0] acc
);
    localparam int ACC_W = DW + FW;

    logic signed [ACC_W:0]   x_ext;
    logic signed [ACC_W:0]   diff;
    logic signed [ACC_W:0]   step;
    logic signed [ACC_W:0]   sum;
    logic [CFG_W-1:0]        shamt;

    assign shamt = clamp_shift(shift_d);
    assign x_ext = {in_data[DW-1], in_data, {FW{1'b0}}};
    assign diff  = x_ext - {acc[ACC_W-1], acc};
    assign step  = diff >>> shamt;
    assign sum   = {acc[ACC_W-1], acc} + step;

    always_ff @(posedge clk) begin
        if (rst || !en)          acc <= '0;
        else if (in_valid && wrap) acc <= x_ext[ACC_W-1:0];
        else if (in_valid)         acc <= sum[ACC_W-1:0];
    end

    // R6: a disabled filter keeps zero state
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc == '0));
    // R10: without a sample the state does not move
    assert_hold_no_sample_R10: assert property (@(posedge clk) disable iff (rst)
        (en && !in_valid) |=> $stable(acc));
endmodule

// File: rtl/dcm_out_stage.sv
module dcm_out_stage
    import dcm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic signed [DW+FW-1:0] acc,
    output logic                    out_valid,
    output logic signed [DW-1:0]    out_data
);
    localparam int ACC_W = DW + FW;
    localparam logic signed [ACC_W:0] HALF = {{(ACC_W-FW+1){1'b0}}, 1'b1, {(FW-1){1'b0}}};

    logic signed [ACC_W:0] rounded;

    assign rounded  = {acc[ACC_W-1], acc} + HALF;
    assign out_data = rounded[ACC_W-1:FW];

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= take;
    end
endmodule

// File: rtl/dc_meas_averager.sv
module dc_meas_averager
    import dcm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CFG_W-1:0]     shift_d,
    input  logic                 clr_en,
    input  logic [CFG_W-1:0]     clr_r,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic                 cfg_error
);
    win_cfg_t                 cfg;
    logic                     wrap;
    logic signed [DW+FW-1:0]  acc;

    assign cfg = '{en: en, clr_en: clr_en, win_exp: clr_r};

    dcm_window_timer #(.CNT_BITS(CNT_W)) i_timer (
        .clk(clk), .rst(rst), .cfg(cfg), .in_valid(in_valid), .wrap(wrap));

    dcm_iir_core #(.DW(DW), .FW(FW)) i_core (
        .clk(clk), .rst(rst), .en(en), .shift_d(shift_d), .in_valid(in_valid),
        .in_data(in_data), .wrap(wrap), .acc(acc));

    dcm_out_stage #(.DW(DW), .FW(FW)) i_out (
        .clk(clk), .rst(rst), .take(in_valid && en), .acc(acc),
        .out_valid(out_valid), .out_data(out_data));

    always_ff @(posedge clk) begin
        if (rst) cfg_error <= 1'b0;
        else     cfg_error <= en && clr_en && (shift_d >= clr_r);
    end

    // R5: a valid pulse needs an accepted sample one cycle before
    assert_valid_origin_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) && $past(en)));
    // R4: zero shift passes the sample through
    assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && en && shift_d == '0) |=> (out_data == $past(in_data)));
endmodule

// File: tb/test_dc_meas_averager.sv
module test_dc_meas_averager;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, clr_en = 1'b0, in_valid = 1'b0;
    logic [4:0] shift_d = '0, clr_r = '0;
    logic signed [15:0] in_data = '0;
    logic out_valid, cfg_error;
    logic signed [15:0] out_data;

    int n_chk = 0, n_bad = 0;
    longint m_acc = 0, m_cnt = 0;
    bit p_en = 0, p_clr = 0;
    logic [4:0] p_r = '0;

    always #2 clk = ~clk;

    dc_meas_averager i_dc_meas_averager (
        .clk(clk), .rst(rst), .en(en), .shift_d(shift_d), .clr_en(clr_en),
        .clr_r(clr_r), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .cfg_error(cfg_error));

    function automatic longint rnd(longint a);
        return (a + (64'sd1 <<< 19)) >>> 20;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(bit v, int x, string tag);
        bit chg, wrap;
        longint ceff, mask, xe;
        int dd;
        bit exp_err;
        in_valid = v;
        in_data = 16'(x);
        xe = longint'(x) <<< 20;
        chg = (en != p_en) || (clr_en != p_clr) || (clr_r != p_r);
        ceff = chg ? 0 : m_cnt;
        if (!en) begin
            m_acc = 0; m_cnt = 0;
        end else begin
            dd = (shift_d > 20) ? 20 : int'(shift_d);
            mask = (64'sd1 <<< clr_r) - 1;
            wrap = clr_en && v && (ceff == mask);
            if (v) m_acc = wrap ? xe : m_acc + ((xe - m_acc) >>> dd);
            if (!clr_en) m_cnt = 0;
            else if (v)  m_cnt = wrap ? 0 : ceff + 1;
            else         m_cnt = ceff;
        end
        p_en = en; p_clr = clr_en; p_r = clr_r;
        exp_err = en && clr_en && (shift_d >= clr_r);
        @(negedge clk);
        chk(out_valid == (v && en), "R5 out_valid", longint'(out_valid), longint'(v && en));
        chk(longint'(out_data) == rnd(m_acc), tag, longint'(out_data), rnd(m_acc));
        chk(cfg_error == exp_err, "R9 cfg_error", longint'(cfg_error), longint'(exp_err));
    endtask

    function automatic int noisy(int base, int amp);
        return base + int'($urandom_range(2 * amp, 0)) - amp;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(out_data == 0, "R1 out_data", out_data, 0);
        chk(cfg_error == 0, "R1 cfg_error", cfg_error, 0);

        // R6: disabled, samples ignored
        for (int i = 0; i < 5; i++) push(1, 1234, "R6 disabled");

        // R4: pass-through at D=0
        en = 1; shift_d = 0;
        for (int i = 0; i < 40; i++) push(1, int'($urandom_range(65535, 0)) - 32768, "R4 pass-through");

        // R2: step response D=4, settling
        shift_d = 4;
        for (int i = 0; i < 30; i++) push(1, 0, "R2 zero");
        for (int i = 0; i < 128; i++) push(1, 1000, "R2 step");
        chk((out_data >= 999) && (out_data <= 1001), "R2 settle", out_data, 1000);

        // R10: gaps keep state
        for (int i = 0; i < 6; i++) push(i % 2, -700, "R10 gap");
        push(0, 5000, "R10 hold");
        chk(out_data == 16'(rnd(m_acc)), "R10 unchanged", out_data, rnd(m_acc));

        // R8: noisy constant, several D, clear off
        for (int k = 0; k < 6; k++) begin
            shift_d = 5'($urandom_range(20, 1));
            for (int i = 0; i < 300; i++) push(($urandom_range(3, 0) != 0), noisy(-9000, 400), "R8 continuous");
        end

        // R3: D=20 then D above 20 match clamp
        shift_d = 20;
        for (int i = 0; i < 200; i++) push(1, noisy(32000, 700), "R3 D=20");
        shift_d = 27;
        for (int i = 0; i < 200; i++) push(1, noisy(-32000, 700), "R3 D>20");
        shift_d = 31;
        for (int i = 0; i < 100; i++) push(1, 32767, "R3 D=31");

        // R7: periodic clear, R=3, D=2
        shift_d = 2; clr_r = 3; clr_en = 1;
        for (int i = 0; i < 7; i++) push(1, 500, "R7 window");
        push(1, -300, "R7 wrap");
        chk(out_data == -300, "R7 direct load", out_data, -300);
        for (int i = 0; i < 60; i++) push(($urandom_range(1, 0) != 0), noisy(200, 3000), "R7 running");
        // R7: change R mid-window restarts count
        for (int i = 0; i < 3; i++) push(1, 800, "R7 pre-change");
        clr_r = 4;
        for (int i = 0; i < 15; i++) push(1, 800, "R7 after change");
        push(1, -1111, "R7 wrap after change");
        chk(out_data == -1111, "R7 restart", out_data, -1111);
        // R7: R=0 loads every sample
        clr_r = 0; shift_d = 5;
        for (int i = 0; i < 10; i++) push(1, noisy(0, 20000), "R7 R=0");

        // R9: D >= R flagged
        clr_r = 6; shift_d = 6;
        for (int i = 0; i < 4; i++) push(1, 50, "R9 equal");
        shift_d = 9;
        push(1, 60, "R9 above");
        shift_d = 2;
        for (int i = 0; i < 70; i++) push(1, noisy(-100, 900), "R9 clear");

        // random mix
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(99, 0) == 0) begin
                en = ($urandom_range(7, 0) != 0);
                clr_en = $urandom_range(1, 0);
                shift_d = 5'($urandom_range(31, 0));
                clr_r = 5'($urandom_range(12, 0));
            end
            push(($urandom_range(3, 0) != 0), noisy(0, 30000), "R2 random");
        end

        // R6: disable clears state
        en = 0;
        push(1, 999, "R6 disable");
        chk(out_data == 0, "R6 zero", out_data, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule